// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block sits on the host side of a byte-wide serial link to a register and DMA engine. A command request carries an opcode, an address, a transfer size or a 32-bit write word, a clockless flag and a CRC enable. The block turns that request into the command bytes in the order the link expects, and hands them out one at a time over a valid/ready byte stream. When the CRC enable is set, it appends a CRC7 check byte.

After the last command byte the block listens on a receive byte strobe for the two-byte reply. The reply must repeat the opcode and then carry a zero status. It reports the result with a single-cycle completion pulse and three error flags. The data phase of block transfers and the serial shifter are handled by neighbouring logic.

Top module: `spicmd_framer`

## Requirements
- R1: After reset, req_ready is 1 and tx_valid, done, err_opcode, err_echo and err_status are all 0.
- R2: A single read (0xCA) emits 4 bytes: the opcode, then address bits 23:16, 15:8 and 7:0.
- R3: A single write (0xC9) emits 8 bytes: the opcode, the 3 address bytes most significant first, then the write word as bits 31:24, 23:16, 15:8, 7:0.
- R4: Internal commands send a 2-byte address. The first address byte has bit 7 equal to the clockless flag and bits 6:0 equal to address bits 14:8. The second is address bits 7:0. An internal read (0xC4) then sends one 0x00 byte (4 bytes in total). An internal write (0xC3) then sends the 4 write bytes most significant first (7 bytes in total).
- R5: DMA commands 0xC1/0xC2 emit the opcode, the 3 address bytes and 2 size bytes (size 15:8, 7:0). Extended DMA commands 0xC7/0xC8 emit the opcode, the 3 address bytes and 3 size bytes (size 23:16, 15:8, 7:0), most significant first.
- R6: Reset (0xCF) emits the opcode then 0xFF 0xFF 0xFF. Terminate (0xC5) and repeat (0xC6) emit the opcode then three 0x00 bytes. The request address has no effect on these bytes.
- R7: With crc_en set at acceptance, one more byte follows the frame. It is the CRC7 of all earlier frame bytes: polynomial x^7+x^3+1, register seeded with all ones, bits fed most significant first. The 7-bit result sits in bits 7:1 and bit 0 is 0.
- R8: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data holds its value. A byte advances only on a handshake. req_ready is 0 from acceptance until the cycle after done.
- R9: After the last frame byte, received bytes are checked in order. For 0xC5, 0xC6 and 0xCF the first byte is skipped. The next byte must equal the opcode, or err_echo is set. The byte after it must be 0x00, or err_status is set. done pulses for one cycle in the cycle after the status byte is taken.
- R10: For an internal command (0xC3/0xC4) with the clockless flag set, neither an echo mismatch nor a nonzero status sets an error flag.
- R11: Any other opcode emits no byte. It produces done in the cycle after acceptance, with err_opcode 1 and the other two flags 0.
- R12: The error flags change only together with done and hold until the next done. Received bytes that arrive while the frame is still being sent are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 8 | Opcode |
| req_addr | input | 24 | Target address |
| req_size | input | 24 | DMA transfer size |
| req_wdata | input | 32 | Write word |
| req_clockless | input | 1 | Clockless flag for internal commands |
| crc_en | input | 1 | Append CRC7 byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte taken |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| done | output | 1 | Command finished (one cycle) |
| err_opcode | output | 1 | Unsupported opcode |
| err_echo | output | 1 | Reply did not repeat the opcode |
| err_status | output | 1 | Reply status nonzero |

## Verification
Four properties are checked on every cycle:
- the outgoing byte holds under back-pressure;
- the block stays busy while it streams;
- completion is a single-cycle pulse and the error flags move only with it;
- a relaxed clockless reply never raises an error.

The byte contents are shown only by the bench's scenarios, which compare each frame against an independently built expected sequence. These cover the frame layout of every command family, the CRC byte value, the skip byte, and the timing of done relative to the status byte.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 24;
  localparam int SIZE_W   = 24;
  localparam int DATA_W   = 32;
  localparam int CRC_W    = 7;
  localparam int MAX_BODY = 8;
  localparam int IDX_W    = $clog2(MAX_BODY);
  localparam int LEN_W    = $clog2(MAX_BODY + 2);

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_SGL_WR  = 8'hC9;
  localparam logic [7:0] OP_SGL_RD  = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [2:0] {
    FMT_BAD, FMT_RD3, FMT_WR3, FMT_IRD, FMT_IWR, FMT_DMA2, FMT_DMA3, FMT_SPEC
  } fmt_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RESP} state_e;

  function automatic fmt_e classify(input logic [7:0] op);
    case (op)
      OP_SGL_RD:               return FMT_RD3;
      OP_SGL_WR:               return FMT_WR3;
      OP_INT_RD:               return FMT_IRD;
      OP_INT_WR:               return FMT_IWR;
      OP_DMA_WR, OP_DMA_RD:    return FMT_DMA2;
      OP_XDMA_WR, OP_XDMA_RD:  return FMT_DMA3;
      OP_TERM, OP_REPEAT,
      OP_RESET:                return FMT_SPEC;
      default:                 return FMT_BAD;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] crc7_byte(input logic [CRC_W-1:0] cur,
                                                 input logic [7:0] din);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cur;
    for (int b = 7; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ din[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/spicmd_layout.sv
module spicmd_layout
  import spicmd_pkg::*;
(
  input  logic [7:0]                  op,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [SIZE_W-1:0]           size,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        clockless,
  output logic [MAX_BODY-1:0][7:0]    body,
  output logic [LEN_W-1:0]            len,
  output logic                        skip,
  output logic                        lax,
  output logic                        legal
);
  localparam int NA = ADDR_W / BYTE_W;
  localparam int NS = SIZE_W / BYTE_W;
  localparam int ND = DATA_W / BYTE_W;

  logic [NA-1:0][7:0] addr_be;
  logic [NS-1:0][7:0] size_be;
  logic [ND-1:0][7:0] data_be;

  // Byte k of each field is the k-th most significant byte.
  for (genvar g = 0; g < NA; g++) begin : g_addr
    assign addr_be[g] = addr[ADDR_W-1-g*BYTE_W -: BYTE_W];
  end
  for (genvar g = 0; g < NS; g++) begin : g_size
    assign size_be[g] = size[SIZE_W-1-g*BYTE_W -: BYTE_W];
  end
  for (genvar g = 0; g < ND; g++) begin : g_data
    assign data_be[g] = wdata[DATA_W-1-g*BYTE_W -: BYTE_W];
  end

  fmt_e fmt;
  assign fmt = classify(op);

  always_comb begin
    body    = '0;
    body[0] = op;
    len     = '0;
    skip    = 1'b0;
    lax     = 1'b0;
    legal   = 1'b1;
    case (fmt)
      FMT_RD3: begin
        for (int k = 0; k < NA; k++) body[1+k] = addr_be[k];
        len = LEN_W'(1 + NA);
      end
      FMT_WR3: begin
        for (int k = 0; k < NA; k++) body[1+k] = addr_be[k];
        for (int k = 0; k < ND; k++) body[1+NA+k] = data_be[k];
        len = LEN_W'(1 + NA + ND);
      end
      FMT_IRD: begin
        body[1] = {clockless, addr[14:8]};
        body[2] = addr[7:0];
        body[3] = 8'h00;
        len     = LEN_W'(4);
        lax     = clockless;
      end
      FMT_IWR: begin
        body[1] = {clockless, addr[14:8]};
        body[2] = addr[7:0];
        for (int k = 0; k < ND; k++) body[3+k] = data_be[k];
        len     = LEN_W'(3 + ND);
        lax     = clockless;
      end
      FMT_DMA2: begin
        for (int k = 0; k < NA; k++) body[1+k] = addr_be[k];
        body[1+NA] = size[15:8];
        body[2+NA] = size[7:0];
        len = LEN_W'(3 + NA);
      end
      FMT_DMA3: begin
        for (int k = 0; k < NA; k++) body[1+k] = addr_be[k];
        for (int k = 0; k < NS; k++) body[1+NA+k] = size_be[k];
        len = LEN_W'(1 + NA + NS);
      end
      FMT_SPEC: begin
        for (int k = 0; k < NA; k++) body[1+k] = (op == OP_RESET) ? 8'hFF : 8'h00;
        len  = LEN_W'(1 + NA);
        skip = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/spicmd_crc7.sv
module spicmd_crc7
  import spicmd_pkg::*;
#(
  parameter logic [CRC_W-1:0] SEED = CRC_SEED
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic [7:0] din,
  output logic [7:0] crc_byte
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (clear)  crc_q <= SEED;
    else if (step)   crc_q <= crc7_byte(crc_q, din);
  end

  assign crc_byte = {crc_q, 1'b0};
endmodule

// File: rtl/spicmd_resp.sv
module spicmd_resp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       active,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic [7:0] op,
  input  logic       skip,
  input  logic       lax,
  output logic       fin,
  output logic       echo_err,
  output logic       status_err
);
  logic [1:0] pos_q;
  logic       echo_bad_q;
  logic       take, at_echo;
  logic [1:0] echo_pos;

  assign take     = active && rx_valid;
  assign echo_pos = {1'b0, skip};
  assign at_echo  = take && (pos_q == echo_pos);
  assign fin      = take && (pos_q == echo_pos + 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      echo_bad_q <= 1'b0;
    end else if (start) begin
      pos_q      <= '0;
      echo_bad_q <= 1'b0;
    end else if (take && !fin) begin
      pos_q <= pos_q + 2'd1;
      if (at_echo) echo_bad_q <= (rx_data != op);
    end
  end

  assign echo_err   = echo_bad_q && !lax;
  assign status_err = (rx_data != 8'h00) && !lax;
endmodule

// File: rtl/spicmd_framer.sv
module spicmd_framer
  import spicmd_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_INIT = CRC_SEED
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_op,
  input  logic [23:0] req_addr,
  input  logic [23:0] req_size,
  input  logic [31:0] req_wdata,
  input  logic        req_clockless,
  input  logic        crc_en,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        done,
  output logic        err_opcode,
  output logic        err_echo,
  output logic        err_status
);
  state_e                   state_q;
  logic [MAX_BODY-1:0][7:0] frame_q;
  logic [LEN_W-1:0]         len_q, idx_q;
  logic                     skip_q, lax_q, crc_on_q;
  logic [7:0]               op_q;
  logic                     done_q, err_op_q, err_echo_q, err_stat_q;

  logic [MAX_BODY-1:0][7:0] lay_body;
  logic [LEN_W-1:0]         lay_len;
  logic                     lay_skip, lay_lax, lay_legal;

  logic       accept, tx_fire, on_crc, last_byte;
  logic [7:0] body_byte, crc_byte;
  logic       resp_fin, resp_echo_err, resp_status_err;

  spicmd_layout u_layout (
    .op        (req_op),
    .addr      (req_addr),
    .size      (req_size),
    .wdata     (req_wdata),
    .clockless (req_clockless),
    .body      (lay_body),
    .len       (lay_len),
    .skip      (lay_skip),
    .lax       (lay_lax),
    .legal     (lay_legal)
  );

  assign req_ready = (state_q == ST_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;
  assign tx_valid  = (state_q == ST_SEND);
  assign tx_fire   = tx_valid && tx_ready;
  assign on_crc    = (idx_q == len_q);
  assign body_byte = frame_q[idx_q[IDX_W-1:0]];
  assign tx_data   = on_crc ? crc_byte : body_byte;
  assign last_byte = crc_on_q ? on_crc : (idx_q == len_q - LEN_W'(1));

  spicmd_crc7 #(.SEED(CRC_INIT)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .step     (tx_fire && !on_crc),
    .din      (body_byte),
    .crc_byte (crc_byte)
  );

  spicmd_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .active     (state_q == ST_RESP),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .op         (op_q),
    .skip       (skip_q),
    .lax        (lax_q),
    .fin        (resp_fin),
    .echo_err   (resp_echo_err),
    .status_err (resp_status_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      frame_q    <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      skip_q     <= 1'b0;
      lax_q      <= 1'b0;
      crc_on_q   <= 1'b0;
      op_q       <= '0;
      done_q     <= 1'b0;
      err_op_q   <= 1'b0;
      err_echo_q <= 1'b0;
      err_stat_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (lay_legal) begin
            state_q  <= ST_SEND;
            frame_q  <= lay_body;
            len_q    <= lay_len;
            idx_q    <= '0;
            skip_q   <= lay_skip;
            lax_q    <= lay_lax;
            crc_on_q <= crc_en;
            op_q     <= req_op;
          end else begin
            done_q     <= 1'b1;
            err_op_q   <= 1'b1;
            err_echo_q <= 1'b0;
            err_stat_q <= 1'b0;
          end
        end
        ST_SEND: if (tx_fire) begin
          idx_q <= idx_q + LEN_W'(1);
          if (last_byte) state_q <= ST_RESP;
        end
        ST_RESP: if (resp_fin) begin
          state_q    <= ST_IDLE;
          done_q     <= 1'b1;
          err_op_q   <= 1'b0;
          err_echo_q <= resp_echo_err;
          err_stat_q <= resp_status_err;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign err_opcode = err_op_q;
  assign err_echo   = err_echo_q;
  assign err_status = err_stat_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({err_opcode, err_echo, err_status}));

  assert_lax_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && lax_q && !err_opcode |-> !err_echo && !err_status);
endmodule

// File: tb/spicmd_framer_test.sv
module spicmd_framer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [23:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_clockless = 1'b0;
  logic        crc_en = 1'b0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        done, err_opcode, err_echo, err_status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spicmd_framer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_clockless(req_clockless), .crc_en(crc_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
    .err_opcode(err_opcode), .err_echo(err_echo), .err_status(err_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc();
    int r = 'h7F;
    foreach (exp_q[i])
      for (int b = 7; b >= 0; b--) begin
        int fb = ((r >> 6) & 1) ^ ((exp_q[i] >> b) & 1);
        r = (r << 1) & 'h7F;
        if (fb != 0) r = r ^ 'h09;
      end
    return 8'(r << 1);
  endfunction

  function automatic void ref_frame(input logic [7:0] op, input logic [23:0] a,
                                    input logic [23:0] s, input logic [31:0] w,
                                    input bit cl, input bit crc);
    exp_q.delete();
    exp_q.push_back(op);
    if (op == 8'hC3 || op == 8'hC4) begin
      exp_q.push_back({cl, a[14:8]});
      exp_q.push_back(a[7:0]);
      if (op == 8'hC4) exp_q.push_back(8'h00);
    end else if (op == 8'hCF) begin
      repeat (3) exp_q.push_back(8'hFF);
    end else if (op == 8'hC5 || op == 8'hC6) begin
      repeat (3) exp_q.push_back(8'h00);
    end else begin
      for (int sh = 16; sh >= 0; sh -= 8) exp_q.push_back(8'(a >> sh));
    end
    if (op == 8'hC1 || op == 8'hC2)
      for (int sh = 8; sh >= 0; sh -= 8) exp_q.push_back(8'(s >> sh));
    if (op == 8'hC7 || op == 8'hC8)
      for (int sh = 16; sh >= 0; sh -= 8) exp_q.push_back(8'(s >> sh));
    if (op == 8'hC3 || op == 8'hC9)
      for (int sh = 24; sh >= 0; sh -= 8) exp_q.push_back(8'(w >> sh));
    if (crc) exp_q.push_back(ref_crc());
  endfunction

  // All driving and sampling happens at the falling edge.
  task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input logic [23:0] s,
                         input logic [31:0] w, input bit cl, input bit crc,
                         input bit stall, input bit noise,
                         input logic [7:0] echo, input logic [7:0] stat,
                         input bit exp_eecho, input bit exp_estat, input string tag);
    int n, k, cyc;
    bit spec;
    logic [7:0] resp[$];
    ref_frame(op, a, s, w, cl, crc);
    n = exp_q.size();
    spec = (op == 8'hC5 || op == 8'hC6 || op == 8'hCF);
    check(req_ready == 1'b1, {tag, " R8 ready before request"}, req_ready, 1);
    req_op = op; req_addr = a; req_size = s; req_wdata = w;
    req_clockless = cl; crc_en = crc; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 0;
    while (k < n && cyc < 200) begin
      check(tx_valid == 1'b1, {tag, " R8 tx_valid during frame"}, tx_valid, 1);
      check(tx_data == exp_q[k], {tag, " R2 R3 R4 R5 R6 R7 frame byte"}, tx_data, exp_q[k]);
      if (k == 0 && cyc == 0)
        check(req_ready == 1'b0, {tag, " R8 busy while sending"}, req_ready, 0);
      tx_ready = stall ? cyc[0] : 1'b1;
      if (noise) begin rx_valid = 1'b1; rx_data = 8'h5A; end
      @(posedge clk);
      if (tx_ready) k++;
      cyc++;
      @(negedge clk);
      tx_ready = 1'b0; rx_valid = 1'b0;
    end
    check(tx_valid == 1'b0, {tag, " R8 no byte after frame"}, tx_valid, 0);
    if (spec) resp.push_back(8'h77);
    resp.push_back(echo);
    resp.push_back(stat);
    foreach (resp[i]) begin
      check(done == 1'b0, {tag, " R9 no done before status"}, done, 0);
      rx_valid = 1'b1; rx_data = resp[i];
      @(posedge clk); @(negedge clk);
      rx_valid = 1'b0;
    end
    check(done == 1'b1, {tag, " R9 done after status"}, done, 1);
    check(err_echo == exp_eecho, {tag, " R9 R10 err_echo"}, err_echo, exp_eecho);
    check(err_status == exp_estat, {tag, " R9 R10 err_status"}, err_status, exp_estat);
    check(err_opcode == 1'b0, {tag, " R11 err_opcode clear"}, err_opcode, 0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R9 done is one cycle"}, done, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=hang expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check({err_opcode, err_echo, err_status} == 3'b000, "R1 errors",
          {err_opcode, err_echo, err_status}, 0);

    // R2 single read
    run_cmd(8'hCA, 24'h123456, 24'h0, 32'h0, 0, 0, 0, 0, 8'hCA, 8'h00, 0, 0, "rd");
    // R3 R7 R8 single write with CRC and back-pressure
    run_cmd(8'hC9, 24'hA1B2C3, 24'h0, 32'hDEADBEEF, 0, 1, 1, 0, 8'hC9, 8'h00, 0, 0, "wr");
    // R4 internal read, no clockless, CRC
    run_cmd(8'hC4, 24'h001234, 24'h0, 32'h0, 0, 1, 0, 0, 8'hC4, 8'h00, 0, 0, "ird");
    // R4 R10 internal write clockless, bad echo and status relaxed
    run_cmd(8'hC3, 24'h00007F, 24'h0, 32'h01020304, 1, 0, 1, 0, 8'h00, 8'hEE, 0, 0, "iwr_cl");
    // R10 internal read clockless with CRC, relaxed
    run_cmd(8'hC4, 24'h0055AA, 24'h0, 32'h0, 1, 1, 0, 0, 8'h11, 8'h01, 0, 0, "ird_cl");
    // R9 bad status on strict command, R12 noise ignored during send
    run_cmd(8'hC4, 24'h000A0B, 24'h0, 32'h0, 0, 0, 1, 1, 8'hC4, 8'h03, 0, 1, "ird_bad");
    check(err_status == 1'b1, "R12 err_status held after done", err_status, 1);
    // R5 DMA forms
    run_cmd(8'hC1, 24'h0F0E0D, 24'h00ABCD, 32'h0, 0, 0, 0, 0, 8'hC1, 8'h00, 0, 0, "dma2");
    check(err_status == 1'b0, "R12 flags updated at next done", err_status, 0);
    run_cmd(8'hC8, 24'h102030, 24'h012345, 32'h0, 0, 1, 1, 0, 8'hC8, 8'h00, 0, 0, "dma3");
    // R6 specials with skip byte
    run_cmd(8'hCF, 24'h123456, 24'h0, 32'h0, 0, 1, 0, 0, 8'hCF, 8'h00, 0, 0, "reset");
    run_cmd(8'hC5, 24'hFFFFFF, 24'h0, 32'h0, 1, 0, 0, 0, 8'hC6, 8'h00, 1, 0, "term");
    run_cmd(8'hC6, 24'h0000AA, 24'h0, 32'h0, 0, 0, 1, 0, 8'hC6, 8'h00, 0, 0, "repeat");

    // R11 unsupported opcode
    req_op = 8'hC0; req_valid = 1'b1; crc_en = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b1, "R11 done next cycle", done, 1);
    check(err_opcode == 1'b1, "R11 err_opcode", err_opcode, 1);
    check({err_echo, err_status} == 2'b00, "R11 other flags", {err_echo, err_status}, 0);
    check(tx_valid == 1'b0, "R11 no byte", tx_valid, 0);
    check(req_ready == 1'b0, "R8 not ready during done", req_ready, 0);
    @(negedge clk);
    check(done == 1'b0, "R11 done one cycle", done, 0);
    check(tx_valid == 1'b0, "R11 still no byte", tx_valid, 0);
    check(err_opcode == 1'b1, "R12 err_opcode held", err_opcode, 1);
    run_cmd(8'hCA, 24'h000001, 24'h0, 32'h0, 0, 1, 0, 0, 8'hCA, 8'h00, 0, 0, "rd_after");
    finish_run();
  end
endmodule